// File: doc/BRIEF.md
# Isochronous Resource Manager Lock Registers

This block keeps the four registers a serial-bus node must expose when it acts as isochronous resource manager. The registers are the bus manager identity, the remaining isochronous bandwidth, and two 32-bit words of channel-availability flags. Agents on the bus claim and return bandwidth and channels through this block. They do so with quadlet reads and compare-swap lock requests. A 64-bit compare-swap covers both channel words at once.

The lock is not a plain compare-swap. The bandwidth register checks the amount moved and does allocate or release arithmetic. The channel words flip only the bits where arg and data differ. Channel 31 is held by the node itself and can never be given back.

Requests arrive on a valid/ready channel, and each one yields one response on a second valid/ready channel. A request is accepted when both `req_valid` and `req_ready` are high at a clock edge. Its whole read-modify-write happens at that edge. Its response is presented from the next cycle and held until `rsp_ready` is seen high. `req_ready` is low while a response waits unaccepted or while `bus_reset` is high. One request is therefore in flight at a time, and every lock is atomic against every other access. A pending response may be consumed and a new request accepted at the same edge. The `bus_reset` input is a plain control pin: for each cycle it is high, it reloads the register defaults.

Top module: `irm_lock_regs`

## Requirements
- R1: After `rst_n` and one cycle after any cycle with `bus_reset` high, the registers hold these defaults: bus manager ID 0x3F, bandwidth 4915, channel high word 0xFFFFFFFE, channel low word 0xFFFFFFFF. Channel 31 is bit 0 of the high word, so it starts out allocated.
- R2: Register offsets are 0x00 (bus manager ID), 0x04 (bandwidth), 0x08 (channel high word) and 0x0C (channel low word). `req_kind` encodes 0 = read, 1 = write, 2 = 32-bit lock, 3 = 64-bit lock. A read at one of these offsets returns the register value, zero-extended, in `rsp_data[31:0]` with code 0 (complete). The response is valid in the cycle after acceptance.
- R3: A bus manager lock returns the old value. It loads `data[5:0]` only when `arg` equals the old value; otherwise the register is unchanged.
- R4: A bandwidth lock whose `arg` exceeds 0x1FFF returns the old value and changes nothing.
- R5: Otherwise `data` is cut to its low 13 bits. If `arg >= data`, the lock allocates `arg - data`. It succeeds only when the old value is at least that amount: the register drops by the amount and `arg` is returned. On failure the old value is returned.
- R6: If `arg < data`, the lock releases `data - arg`. It succeeds only when the old value plus the amount is below 0x2000: the register grows by the amount and `arg` is returned. On failure the old value is returned.
- R7: A channel-word lock computes `affected = arg ^ data`. If `arg & affected` equals `reg & affected`, the word is XORed with `affected` and `arg` is returned. Otherwise the current word is returned unchanged.
- R8: Bit 0 of the channel high word (channel 31) is forced to 0 in `data` before any channel compare. A lock can therefore never set that bit.
- R9: A 64-bit lock at offset 0x08 applies the R7 rule to {high word, low word} as one 64-bit value and returns 64 bits. A 64-bit lock at any other register offset gives code 1 (type error).
- R10: Each of the following returns code 1 (type error), leaves every register unchanged, and sets `rsp_data` to zero: a write, an address with a nonzero low two bits, or a lock whose `req_ext` is not 2 (compare-swap). Every successful or failed compare-swap returns code 0.
- R11: An aligned address beyond 0x0F returns code 2 (address error), with zero data, for every request kind.
- R12: `req_ready` is low while `bus_reset` is high or while `rsp_valid` is high and `rsp_ready` is low. An unaccepted response keeps `rsp_valid`, `rsp_code` and `rsp_data` steady. After reset `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_reset | input | 1 | Reload register defaults while high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_kind | input | 2 | 0 read, 1 write, 2 lock, 3 64-bit lock |
| req_addr | input | 8 | Byte offset of the register |
| req_ext | input | 4 | Extended lock code, 2 = compare-swap |
| req_data | input | 64 | Lock data (low 32 bits for quadlet ops) |
| req_arg | input | 64 | Lock argument (low 32 bits for quadlet ops) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response can be taken |
| rsp_code | output | 2 | 0 complete, 1 type error, 2 address error |
| rsp_data | output | 64 | Old value or returned argument |

## Verification
The assertions take for granted that `req_valid` and the request fields stay at their values from the start of a cycle until the edge that accepts them. They also take for granted that `bus_reset` is never high when a new request is meant to be accepted. The bench drives every request field on the falling edge and keeps it steady across the accepting edge. It pulses `bus_reset` only while no request is offered. Expected results for the state-dependent vector table are worked out by hand from the register values left by the vectors before each one. The table therefore runs as one ordered sequence starting from reset.

// File: rtl/irm_pkg.sv
package irm_pkg;

  typedef enum logic [1:0] {
    K_READ   = 2'd0,
    K_WRITE  = 2'd1,
    K_LOCK   = 2'd2,
    K_LOCK64 = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    RC_COMPLETE = 2'd0,
    RC_TYPE_ERR = 2'd1,
    RC_ADDR_ERR = 2'd2
  } rsp_code_e;

  typedef enum logic [1:0] {
    SEL_BMID = 2'd0,
    SEL_BW   = 2'd1,
    SEL_CHHI = 2'd2,
    SEL_CHLO = 2'd3
  } reg_sel_e;

  typedef struct packed {
    rsp_code_e code;
    reg_sel_e  sel;
    logic      do_read;
    logic      do_lock;
    logic      wide;
  } dec_t;

endpackage

// File: rtl/irm_decode.sv
module irm_decode
  import irm_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int EXT_W      = 4,
  parameter int CSWAP_CODE = 2
) (
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [EXT_W-1:0]  ext,
  output dec_t              dec
);
  localparam int WIN_BITS = 4;
  localparam logic [EXT_W-1:0] CSWAP = EXT_W'(CSWAP_CODE);

  logic in_window;
  assign in_window = (addr[ADDR_W-1:WIN_BITS] == '0);

  always_comb begin
    dec         = '0;
    dec.code    = RC_COMPLETE;
    dec.sel     = reg_sel_e'(addr[3:2]);
    if (addr[1:0] != 2'b00) begin
      dec.code = RC_TYPE_ERR;
    end else if (!in_window) begin
      dec.code = RC_ADDR_ERR;
    end else begin
      unique case (req_kind_e'(kind))
        K_READ:  dec.do_read = 1'b1;
        K_WRITE: dec.code = RC_TYPE_ERR;
        K_LOCK: begin
          if (ext == CSWAP) dec.do_lock = 1'b1;
          else              dec.code    = RC_TYPE_ERR;
        end
        K_LOCK64: begin
          if (ext == CSWAP && reg_sel_e'(addr[3:2]) == SEL_CHHI) begin
            dec.do_lock = 1'b1;
            dec.wide    = 1'b1;
          end else begin
            dec.code = RC_TYPE_ERR;
          end
        end
        default: dec.code = RC_TYPE_ERR;
      endcase
    end
  end
endmodule

// File: rtl/irm_bw_lock.sv
module irm_bw_lock #(
  parameter int Q_W  = 32,
  parameter int BW_W = 13
) (
  input  logic [BW_W-1:0] cur,
  input  logic [Q_W-1:0]  data,
  input  logic [Q_W-1:0]  arg,
  output logic [BW_W-1:0] nxt,
  output logic            upd,
  output logic [Q_W-1:0]  ret
);
  localparam logic [Q_W-1:0] LIMIT = Q_W'((64'd1 << BW_W) - 1);

  logic [BW_W-1:0] arg_n, data_n, amt;
  logic [BW_W:0]   sum;

  assign arg_n  = arg[BW_W-1:0];
  assign data_n = data[BW_W-1:0];

  always_comb begin
    upd = 1'b0;
    nxt = cur;
    ret = Q_W'(cur);
    amt = '0;
    sum = '0;
    if (arg <= LIMIT) begin
      if (arg_n >= data_n) begin
        amt = arg_n - data_n;
        if (cur >= amt) begin
          upd = 1'b1;
          nxt = cur - amt;
          ret = arg;
        end
      end else begin
        amt = data_n - arg_n;
        sum = {1'b0, cur} + {1'b0, amt};
        if (!sum[BW_W]) begin
          upd = 1'b1;
          nxt = sum[BW_W-1:0];
          ret = arg;
        end
      end
    end
  end
endmodule

// File: rtl/irm_chan_lock.sv
module irm_chan_lock #(
  parameter int W = 64
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] data,
  input  logic [W-1:0] arg,
  output logic [W-1:0] nxt,
  output logic         upd,
  output logic [W-1:0] ret
);
  logic [W-1:0] affected;

  assign affected = arg ^ data;
  assign upd      = ((arg & affected) == (cur & affected));
  assign nxt      = cur ^ affected;
  assign ret      = upd ? arg : cur;
endmodule

// File: rtl/irm_lock_regs.sv
module irm_lock_regs
  import irm_pkg::*;
#(
  parameter int          Q_W        = 32,
  parameter int          ADDR_W     = 8,
  parameter int          EXT_W      = 4,
  parameter int          CSWAP_CODE = 2,
  parameter int          BMID_W     = 6,
  parameter int          BW_W       = 13,
  parameter int          BW_INIT    = 4915,
  parameter logic [31:0] CH_HI_INIT = 32'hFFFF_FFFE,
  parameter logic [31:0] CH_LO_INIT = 32'hFFFF_FFFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_reset,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_kind,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [EXT_W-1:0]    req_ext,
  input  logic [2*Q_W-1:0]    req_data,
  input  logic [2*Q_W-1:0]    req_arg,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [1:0]          rsp_code,
  output logic [2*Q_W-1:0]    rsp_data
);
  localparam int D_W = 2 * Q_W;
  localparam logic [BMID_W-1:0] BMID_RST = '1;
  localparam logic [BW_W-1:0]   BW_RST   = BW_W'(BW_INIT);
  localparam logic [Q_W-1:0]    HI_RST   = Q_W'(CH_HI_INIT);
  localparam logic [Q_W-1:0]    LO_RST   = Q_W'(CH_LO_INIT);
  localparam logic [D_W-1:0]    BCAST_BIT = D_W'(1) << Q_W;

  logic [BMID_W-1:0] bmid_q;
  logic [BW_W-1:0]   bw_q;
  logic [Q_W-1:0]    chhi_q, chlo_q;

  dec_t dec;
  logic accept;

  assign req_ready = !bus_reset && (!rsp_valid || rsp_ready);
  assign accept    = req_valid && req_ready;

  irm_decode #(.ADDR_W(ADDR_W), .EXT_W(EXT_W), .CSWAP_CODE(CSWAP_CODE)) u_dec (
    .kind(req_kind), .addr(req_addr), .ext(req_ext), .dec(dec)
  );

  // bus manager identity compare-swap
  logic [Q_W-1:0] bmid_ext;
  logic           bmid_hit;
  assign bmid_ext = {{(Q_W-BMID_W){1'b0}}, bmid_q};
  assign bmid_hit = (req_arg[Q_W-1:0] == bmid_ext);

  // bandwidth arithmetic
  logic [BW_W-1:0] bw_nxt;
  logic            bw_upd;
  logic [Q_W-1:0]  bw_ret;
  irm_bw_lock #(.Q_W(Q_W), .BW_W(BW_W)) u_bw (
    .cur(bw_q), .data(req_data[Q_W-1:0]), .arg(req_arg[Q_W-1:0]),
    .nxt(bw_nxt), .upd(bw_upd), .ret(bw_ret)
  );

  // channel words: quadlet locks embed the other word unchanged in both operands
  logic [D_W-1:0] ch_cur, ch_arg, ch_data, ch_nxt, ch_ret;
  logic           ch_upd;
  assign ch_cur = {chhi_q, chlo_q};

  always_comb begin
    ch_arg  = ch_cur;
    ch_data = ch_cur;
    if (dec.wide) begin
      ch_arg  = req_arg;
      ch_data = req_data;
    end else if (dec.sel == SEL_CHHI) begin
      ch_arg  = {req_arg[Q_W-1:0],  chlo_q};
      ch_data = {req_data[Q_W-1:0], chlo_q};
    end else if (dec.sel == SEL_CHLO) begin
      ch_arg  = {chhi_q, req_arg[Q_W-1:0]};
      ch_data = {chhi_q, req_data[Q_W-1:0]};
    end
    ch_data = ch_data & ~BCAST_BIT;   // channel 31 stays allocated
  end

  irm_chan_lock #(.W(D_W)) u_ch (
    .cur(ch_cur), .data(ch_data), .arg(ch_arg),
    .nxt(ch_nxt), .upd(ch_upd), .ret(ch_ret)
  );

  // response value
  logic [D_W-1:0] rsp_d;
  always_comb begin
    rsp_d = '0;
    if (dec.code == RC_COMPLETE) begin
      if (dec.wide) begin
        rsp_d = ch_ret;
      end else begin
        unique case (dec.sel)
          SEL_BMID: rsp_d = D_W'(bmid_ext);
          SEL_BW:   rsp_d = dec.do_lock ? D_W'(bw_ret) : D_W'(bw_q);
          SEL_CHHI: rsp_d = dec.do_lock ? D_W'(ch_ret[D_W-1:Q_W]) : D_W'(chhi_q);
          SEL_CHLO: rsp_d = dec.do_lock ? D_W'(ch_ret[Q_W-1:0]) : D_W'(chlo_q);
          default:  rsp_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bmid_q <= BMID_RST;
      bw_q   <= BW_RST;
      chhi_q <= HI_RST;
      chlo_q <= LO_RST;
    end else if (bus_reset) begin
      bmid_q <= BMID_RST;
      bw_q   <= BW_RST;
      chhi_q <= HI_RST;
      chlo_q <= LO_RST;
    end else if (accept && dec.do_lock) begin
      if (dec.wide) begin
        if (ch_upd) begin
          chhi_q <= ch_nxt[D_W-1:Q_W];
          chlo_q <= ch_nxt[Q_W-1:0];
        end
      end else begin
        unique case (dec.sel)
          SEL_BMID: if (bmid_hit) bmid_q <= req_data[BMID_W-1:0];
          SEL_BW:   if (bw_upd)   bw_q   <= bw_nxt;
          SEL_CHHI: if (ch_upd)   chhi_q <= ch_nxt[D_W-1:Q_W];
          SEL_CHLO: if (ch_upd)   chlo_q <= ch_nxt[Q_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= 2'd0;
      rsp_data  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_code  <= dec.code;
      rsp_data  <= rsp_d;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // ---------------- assertions ----------------
  assert_bus_reset_defaults_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (bmid_q == BMID_RST && bw_q == BW_RST && chhi_q == HI_RST && chlo_q == LO_RST));

  assert_bmid_miss_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec.do_lock && !dec.wide && dec.sel == SEL_BMID &&
     req_arg[Q_W-1:0] != {{(Q_W-BMID_W){1'b0}}, bmid_q}) |=> $stable(bmid_q));

  assert_bw_only_by_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_reset && !(accept && req_kind == 2'd2 && req_addr == ADDR_W'(4) && req_ext == EXT_W'(CSWAP_CODE)))
    |=> $stable(bw_q));

  assert_chan31_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !chhi_q[0]);

  assert_no_accept_when_blocked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset || (rsp_valid && !rsp_ready)) |-> !req_ready);

  assert_rsp_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_code)));

endmodule

// File: tb/test_irm_lock_regs.sv
`timescale 1ns/1ps
module test_irm_lock_regs;

  typedef struct packed {
    logic [1:0]  kind;
    logic [7:0]  addr;
    logic [3:0]  ext;
    logic [63:0] data;
    logic [63:0] arg;
    logic [1:0]  code;
    logic [63:0] rdata;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 33;
  // ordered from reset: each expected value follows from the vectors before it
  localparam vec_t VEC [NV] = '{
    '{2'd0, 8'h00, 4'd0, 64'h0, 64'h0, 2'd0, 64'h3F, 8'd1},                                 // R1 R2
    '{2'd0, 8'h04, 4'd0, 64'h0, 64'h0, 2'd0, 64'h1333, 8'd1},                               // R1
    '{2'd0, 8'h08, 4'd0, 64'h0, 64'h0, 2'd0, 64'hFFFF_FFFE, 8'd1},                          // R1
    '{2'd0, 8'h0C, 4'd0, 64'h0, 64'h0, 2'd0, 64'hFFFF_FFFF, 8'd1},                          // R1
    '{2'd2, 8'h00, 4'd2, 64'h05, 64'h3F, 2'd0, 64'h3F, 8'd3},                               // R3 hit
    '{2'd2, 8'h00, 4'd2, 64'h07, 64'h3F, 2'd0, 64'h05, 8'd3},                               // R3 miss
    '{2'd0, 8'h00, 4'd0, 64'h0, 64'h0, 2'd0, 64'h05, 8'd3},                                 // R3
    '{2'd2, 8'h04, 4'd2, 64'h1233, 64'h1333, 2'd0, 64'h1333, 8'd5},                         // R5 alloc 0x100
    '{2'd2, 8'h04, 4'd2, 64'h0, 64'h1233, 2'd0, 64'h1233, 8'd5},                            // R5 exact
    '{2'd2, 8'h04, 4'd2, 64'h0, 64'h10, 2'd0, 64'h0, 8'd5},                                 // R5 short
    '{2'd2, 8'h04, 4'd2, 64'h1FFF, 64'h0, 2'd0, 64'h0, 8'd6},                               // R6 to max
    '{2'd2, 8'h04, 4'd2, 64'h1, 64'h0, 2'd0, 64'h1FFF, 8'd6},                               // R6 overflow
    '{2'd2, 8'h04, 4'd2, 64'h0, 64'h2000, 2'd0, 64'h1FFF, 8'd4},                            // R4
    '{2'd2, 8'h04, 4'd2, 64'h0001_0FFF, 64'h1FFF, 2'd0, 64'h1FFF, 8'd5},                    // R5 mask
    '{2'd0, 8'h04, 4'd0, 64'h0, 64'h0, 2'd0, 64'h0FFF, 8'd5},                               // R5
    '{2'd2, 8'h0C, 4'd2, 64'hFFFF_FFF0, 64'hFFFF_FFFF, 2'd0, 64'hFFFF_FFFF, 8'd7},          // R7 take
    '{2'd2, 8'h0C, 4'd2, 64'hFFFF_FFF0, 64'hFFFF_FFFF, 2'd0, 64'hFFFF_FFF0, 8'd7},          // R7 busy
    '{2'd2, 8'h0C, 4'd2, 64'hFFFF_FFF3, 64'hFFFF_FFF0, 2'd0, 64'hFFFF_FFF0, 8'd7},          // R7 give
    '{2'd2, 8'h08, 4'd2, 64'h7FFF_FFFE, 64'hFFFF_FFFE, 2'd0, 64'hFFFF_FFFE, 8'd7},          // R7 high
    '{2'd2, 8'h08, 4'd2, 64'h7FFF_FFFF, 64'h7FFF_FFFE, 2'd0, 64'h7FFF_FFFE, 8'd8},          // R8 masked
    '{2'd0, 8'h08, 4'd0, 64'h0, 64'h0, 2'd0, 64'h7FFF_FFFE, 8'd8},                          // R8
    '{2'd2, 8'h08, 4'd2, 64'h7FFF_FFFF, 64'h7FFF_FFFF, 2'd0, 64'h7FFF_FFFE, 8'd8},          // R8
    '{2'd3, 8'h08, 4'd2, 64'h3FFF_FFFE_FFFF_FFFF, 64'h7FFF_FFFE_FFFF_FFF3, 2'd0,
      64'h7FFF_FFFE_FFFF_FFF3, 8'd9},                                                        // R9 ok
    '{2'd3, 8'h08, 4'd2, 64'h3FFF_FFFE_FFFF_FFFF, 64'h7FFF_FFFE_FFFF_FFF3, 2'd0,
      64'h3FFF_FFFE_FFFF_FFFF, 8'd9},                                                        // R9 busy
    '{2'd3, 8'h04, 4'd2, 64'h0, 64'h0, 2'd1, 64'h0, 8'd9},                                  // R9
    '{2'd3, 8'h0C, 4'd2, 64'h0, 64'h0, 2'd1, 64'h0, 8'd9},                                  // R9
    '{2'd1, 8'h04, 4'd0, 64'h5, 64'h0, 2'd1, 64'h0, 8'd10},                                 // R10 write
    '{2'd0, 8'h06, 4'd0, 64'h0, 64'h0, 2'd1, 64'h0, 8'd10},                                 // R10 align
    '{2'd2, 8'h00, 4'd1, 64'h3F, 64'h05, 2'd1, 64'h0, 8'd10},                               // R10 ext
    '{2'd0, 8'h10, 4'd0, 64'h0, 64'h0, 2'd2, 64'h0, 8'd11},                                 // R11
    '{2'd2, 8'h3C, 4'd2, 64'h0, 64'h0, 2'd2, 64'h0, 8'd11},                                 // R11
    '{2'd0, 8'h00, 4'd0, 64'h0, 64'h0, 2'd0, 64'h05, 8'd10},                                // R10 untouched
    '{2'd0, 8'h04, 4'd0, 64'h0, 64'h0, 2'd0, 64'h0FFF, 8'd10}                               // R10 untouched
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_reset = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'd0;
  logic [7:0]  req_addr = 8'h0;
  logic [3:0]  req_ext = 4'd0;
  logic [63:0] req_data = 64'h0;
  logic [63:0] req_arg = 64'h0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [1:0]  rsp_code;
  logic [63:0] rsp_data;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  irm_lock_regs i_irm_lock_regs (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .req_ext(req_ext), .req_data(req_data), .req_arg(req_arg),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code), .rsp_data(rsp_data)
  );

  task automatic chk(input int r, input logic [63:0] act, input logic [63:0] exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge the response appears
  task automatic issue(input logic [1:0] k, input logic [7:0] a, input logic [3:0] e,
                       input logic [63:0] d, input logic [63:0] g,
                       output logic [1:0] c, output logic [63:0] r);
    req_kind = k; req_addr = a; req_ext = e; req_data = d; req_arg = g;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    c = rsp_code;
    r = rsp_data;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [1:0]  c;
    logic [63:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(12, 64'(rsp_valid), 64'h0, "rsp_valid after reset");
    chk(12, 64'(req_ready), 64'h1, "req_ready after reset");

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].kind, VEC[i].addr, VEC[i].ext, VEC[i].data, VEC[i].arg, c, r);
      chk(int'(VEC[i].req), 64'(c), 64'(VEC[i].code), $sformatf("vector %0d code", i));
      chk(int'(VEC[i].req), r, VEC[i].rdata, $sformatf("vector %0d data", i));
    end

    // R1: bus reset restores defaults; R12: no acceptance meanwhile
    @(negedge clk);
    bus_reset = 1'b1;
    #1 chk(12, 64'(req_ready), 64'h0, "req_ready during bus_reset");
    @(negedge clk);
    bus_reset = 1'b0;
    issue(2'd0, 8'h00, 4'd0, 64'h0, 64'h0, c, r); chk(1, r, 64'h3F, "bmid after bus_reset");
    issue(2'd0, 8'h04, 4'd0, 64'h0, 64'h0, c, r); chk(1, r, 64'h1333, "bw after bus_reset");
    issue(2'd0, 8'h08, 4'd0, 64'h0, 64'h0, c, r); chk(1, r, 64'hFFFF_FFFE, "hi after bus_reset");
    issue(2'd0, 8'h0C, 4'd0, 64'h0, 64'h0, c, r); chk(1, r, 64'hFFFF_FFFF, "lo after bus_reset");

    // R12: back-pressure on the response
    @(negedge clk);
    rsp_ready = 1'b0;
    req_kind = 2'd0; req_addr = 8'h04; req_ext = 4'd0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(12, 64'(rsp_valid), 64'h1, "first response valid");
    chk(12, rsp_data, 64'h1333, "first response data");
    req_addr = 8'h00;
    #1 chk(12, 64'(req_ready), 64'h0, "req_ready while response stalled");
    @(posedge clk);
    @(negedge clk);
    chk(12, 64'(rsp_valid), 64'h1, "response held valid");
    chk(12, rsp_data, 64'h1333, "response held data");
    rsp_ready = 1'b1;
    #1 chk(12, 64'(req_ready), 64'h1, "req_ready once consumer ready");
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(12, 64'(rsp_valid), 64'h1, "second response valid");
    chk(12, rsp_data, 64'h3F, "second response data");
    @(posedge clk);
    @(negedge clk);
    chk(12, 64'(rsp_valid), 64'h0, "response drained");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule